// File: doc/BRIEF.md
# Dual-Code Serial Line Encoder

This block turns a serial NRZ bit stream into a line signal in one of two codes, chosen per bit: a split-phase code, where every bit carries a mid-bit transition, or a transition-on-one code, where a one inverts the line and a zero leaves it alone. The encoder runs on a clock at twice the bit rate, so each bit period is two clock cycles. A free-running half-bit phase flag, visible at the ports, tells the data source when a new bit period starts.

The source presents the data bit and the code select while the phase flag is low. Both are captured on that clock edge and held for the whole bit period. The line level for each half-bit comes from an output register. Input bits that arrive skewed against the clock therefore cannot glitch the line; they only affect the register at the next capture edge.

Top module: `nrz_line_coder`

## Requirements
- R1: A synchronous active-high reset clears the phase flag to 0 and the line output to 0. The first bit after reset treats 0 as the previous line level.
- R2: The phase flag toggles on every clock edge, so a bit period is exactly two clock cycles. A bit period starts at the edge where the flag is 0.
- R3: The data bit and the code select are captured only at the edge where the phase flag is 0. Changes to either input during the second cycle of a bit period have no effect on that bit.
- R4: In split-phase mode (code select 0), a data 0 drives the line to 0 for the first half-bit and to 1 for the second half-bit.
- R5: In split-phase mode, a data 1 drives the line to 1 for the first half-bit and to 0 for the second half-bit.
- R6: In transition mode (code select 1), a data 0 holds the line at the level of the previous half-bit for both halves of the bit.
- R7: In transition mode, a data 1 drives the complement of the previous half-bit's line level and holds it for both halves.
- R8: The line output is registered. The first-half level of a bit appears one clock after the capture edge, while the phase flag reads 1. The second-half level follows one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock, two cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| nrzi_sel | input | 1 | Code select: 0 split-phase, 1 transition-on-one; captured at bit start |
| nrz_in | input | 1 | NRZ data bit; captured at bit start |
| half_phase | output | 1 | Half-bit flag: 0 means the next edge starts a bit period |
| line_out | output | 1 | Registered encoded line level |

## Verification
A phase flag that slips by one cycle swaps the capture edge. Within the next half-bit, split-phase output then shows the complement of the data where the data value was expected. A wrong held code select or held data bit shows at the second half-bit, one clock after the capture edge: the mid-bit transition is missing in split-phase mode, or an extra one appears in transition mode. A wrong previous level in transition mode inverts every later bit. It is therefore visible at the first one-bit after the fault and stays visible.

// File: rtl/line_code_pkg.sv
package line_code_pkg;
  typedef enum logic {
    CODE_SPLIT = 1'b0,
    CODE_TRANS = 1'b1
  } code_e;

  typedef struct packed {
    code_e mode;
    logic  data;
  } bit_req_t;
endpackage

// File: rtl/lc_phase_gen.sv
module lc_phase_gen (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end
endmodule

// File: rtl/lc_bit_latch.sv
module lc_bit_latch
  import line_code_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  bit_req_t req_in,
  output bit_req_t req_q
);
  always_ff @(posedge clk) begin
    if (rst)       req_q <= '{mode: CODE_SPLIT, data: 1'b0};
    else if (load) req_q <= req_in;
  end
endmodule

// File: rtl/lc_level_calc.sv
module lc_level_calc
  import line_code_pkg::*;
(
  input  bit_req_t req,
  input  logic     second_half,
  input  logic     cur_level,
  output logic     next_level
);
  always_comb begin
    unique case (req.mode)
      CODE_SPLIT: next_level = second_half ? ~req.data : req.data;
      CODE_TRANS: next_level = second_half ? cur_level : (cur_level ^ req.data);
      default:    next_level = cur_level;
    endcase
  end
endmodule

// File: rtl/nrz_line_coder.sv
module nrz_line_coder
  import line_code_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nrzi_sel,
  input  logic nrz_in,
  output logic half_phase,
  output logic line_out
);
  logic     phase_q;
  logic     bit_start;
  bit_req_t in_req;
  bit_req_t held_req;
  bit_req_t use_req;
  logic     level_d;
  logic     line_q;
  logic     held_trans;

  lc_phase_gen u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_q)
  );

  assign bit_start = ~phase_q;
  assign in_req    = '{mode: code_e'(nrzi_sel), data: nrz_in};

  lc_bit_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .load   (bit_start),
    .req_in (in_req),
    .req_q  (held_req)
  );

  // First half uses the request being captured; second half uses the held one.
  assign use_req = bit_start ? in_req : held_req;

  lc_level_calc u_calc (
    .req         (use_req),
    .second_half (phase_q),
    .cur_level   (line_q),
    .next_level  (level_d)
  );

  always_ff @(posedge clk) begin
    if (rst) line_q <= IDLE_LEVEL;
    else     line_q <= level_d;
  end

  assign held_trans = (held_req.mode == CODE_TRANS);
  assign half_phase = phase_q;
  assign line_out   = line_q;
endmodule

// File: rtl/nrz_line_coder_chk.sv
module nrz_line_coder_chk (
  input logic clk,
  input logic rst,
  input logic nrz_in,
  input logic half_phase,
  input logic line_out,
  input logic held_trans
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!seen_rst)
    (!rst && $past(rst)) |-> (!half_phase && !line_out));

  // R2
  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !$past(rst) |-> (half_phase != $past(half_phase)));

  // R4, R5, R8
  a_r5_split_first: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && half_phase && !held_trans) |-> (line_out == $past(nrz_in)));

  // R4, R5
  a_r4_split_second: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && !half_phase && !held_trans) |-> (line_out != $past(line_out)));

  // R6, R7, R8
  a_r7_trans_first: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && half_phase && held_trans) |-> (line_out == ($past(nrz_in) ^ $past(line_out))));

  // R6
  a_r6_trans_second: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!$past(rst) && !half_phase && held_trans) |-> $stable(line_out));
endmodule

bind nrz_line_coder nrz_line_coder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .nrz_in     (nrz_in),
  .half_phase (half_phase),
  .line_out   (line_out),
  .held_trans (held_trans)
);

// File: tb/tb_nrz_line_coder.sv
module tb_nrz_line_coder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrzi_sel = 1'b0;
  logic nrz_in = 1'b0;
  logic half_phase;
  logic line_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  nrz_line_coder dut (
    .clk        (clk),
    .rst        (rst),
    .nrzi_sel   (nrzi_sel),
    .nrz_in     (nrz_in),
    .half_phase (half_phase),
    .line_out   (line_out)
  );

  always #10 clk = ~clk;

  // Entry: {mode, data, expected first half, expected second half}
  localparam int NV = 14;
  localparam logic [3:0] VEC [NV] = '{
    4'b0001, 4'b0110, 4'b1111, 4'b1011, 4'b1100, 4'b1111, 4'b0110,
    4'b1000, 4'b1111, 4'b0001, 4'b1100, 4'b1000, 4'b0001, 4'b0001
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 line after reset", line_out, 1'b0);
    chk("R1 phase after reset", half_phase, 1'b0);

    for (int i = 0; i < NV; i++) begin
      nrzi_sel = VEC[i][3];
      nrz_in   = VEC[i][2];
      @(negedge clk);
      chk("R8 R4 R5 R6 R7 first half", line_out, VEC[i][1]);
      chk("R2 phase first half", half_phase, 1'b1);
      // R3: disturb both inputs mid-bit; the bit must not change.
      nrzi_sel = ~VEC[i][3];
      nrz_in   = ~VEC[i][2];
      @(negedge clk);
      chk("R3 R4 R5 R6 R7 second half", line_out, VEC[i][0]);
      chk("R2 phase second half", half_phase, 1'b0);
    end

    // R1: reset mid-stream with the line high, then transition-mode one from level 0.
    nrzi_sel = 1'b0;
    nrz_in   = 1'b1;
    @(negedge clk);
    chk("R5 line high before reset", line_out, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 line cleared by reset", line_out, 1'b0);
    chk("R1 phase cleared by reset", half_phase, 1'b0);
    rst = 1'b0;
    nrzi_sel = 1'b1;
    nrz_in   = 1'b1;
    @(negedge clk);
    chk("R1 R7 first bit after reset", line_out, 1'b1);
    nrz_in = 1'b0;
    @(negedge clk);
    chk("R7 second half after reset", line_out, 1'b1);
    // R6: a run of transition-mode zeros holds the level.
    nrz_in = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R6 zero run hold", line_out, 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule